// File: doc/BRIEF.md
# Measurement Alert Driver

This block generates the pull-down enable for an active-low, open-drain alert line on a measurement device. A single mode bit in the upper configuration byte selects one of two behaviours. In data-ready mode the line is pulled low when a fresh measurement is latched into the result register. It is released when a bus master has read that result. In threshold mode the line is pulled low while the most recent measurement exceeds a seven-bit signed limit. Voltage, current and power results are handled the same way.

The surrounding logic supplies three things: a one-cycle pulse for each result update, a one-cycle pulse when a result read over the bus completes, and the 16-bit two's complement result that is present during the update pulse. It also supplies the upper configuration byte. The block returns one bit: high means the pad driver must sink current, low means the pad is left high-impedance. All state is reset synchronously.

Top module: `alert_drive`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pull_low` is 0. The stored mode is data-ready, and both the pending-data flag and the over-limit flag are clear.
- R2: In data-ready mode (`cfg_hi[0]` = 0), a cycle with `data_new` = 1 makes `pull_low` = 1 from the next clock edge.
- R3: In data-ready mode, a cycle with `result_rd` = 1 and `data_new` = 0 makes `pull_low` = 0 from the next clock edge.
- R4: When `data_new` and `result_rd` are both 1 in the same data-ready cycle, `pull_low` is 1 after the edge.
- R5: In data-ready mode, an asserted `pull_low` stays asserted until a read, however many cycles pass.
- R6: On each cycle with `data_new` = 1, the over-limit flag is loaded with the signed comparison `result` > (`cfg_hi[7:1]` followed by nine zero bits). In threshold mode (`cfg_hi[0]` = 1), `pull_low` equals this flag from the next edge. `cfg_hi[7:1]` is the limit, two's complement, and its LSB has the weight of result bit 9.
- R7: In threshold mode, `pull_low` does not change between updates. A change of `cfg_hi[7:1]` or a `result_rd` pulse has no effect until the next `data_new`.
- R8: A change of `cfg_hi[0]` without `data_new` clears the pending-data flag. After a return to data-ready mode, `pull_low` is therefore 0.
- R9: The over-limit flag is updated in both modes. Switching to threshold mode shows the result of the latest update from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_new | input | 1 | One-cycle pulse: a new result is latched |
| result_rd | input | 1 | One-cycle pulse: the result register has been read over the bus |
| result | input | 16 | Two's complement result, valid while `data_new` is high |
| cfg_hi | input | 8 | Configuration bits 15..8: [0] mode (0 data-ready, 1 threshold), [7:1] signed limit |
| pull_low | output | 1 | 1 = sink the alert pad low, 0 = leave it high-impedance |

## Verification
Every result is one edge behind its cause. The update pulse, the read pulse and a mode change are all sampled at a clock edge, and they show on `pull_low` right after that edge. The bench drives inputs on the falling edge and samples one time unit after the following rising edge. In every cycle it compares against a reference model advanced at that same edge. Directed sequences cover simultaneous update and read, mode flips and limit edges at ±1 count. These are followed by seeded random traffic.

// File: rtl/alert_pkg.sv
package alert_pkg;

    typedef enum logic {
        MODE_READY = 1'b0,
        MODE_LIMIT = 1'b1
    } alert_mode_e;

    typedef struct packed {
        logic [6:0]  limit;
        alert_mode_e mode;
    } alert_cfg_t;

    // Signed compare of a result word against a limit that covers only its top bits.
    function automatic logic over_limit(input logic [15:0] res, input logic [6:0] lim);
        logic signed [15:0] res_s;
        logic signed [15:0] lim_s;
        res_s = $signed(res);
        lim_s = $signed({lim, 9'd0});
        return res_s > lim_s;
    endfunction

endpackage

// File: rtl/alert_cfg_split.sv
module alert_cfg_split #(
    parameter int CFG_W = 8
) (
    input  logic [CFG_W-1:0]       cfg_in,
    output alert_pkg::alert_cfg_t  cfg_out
);
    localparam int LIM_W = CFG_W - 1;

    always_comb begin
        cfg_out.mode  = alert_pkg::alert_mode_e'(cfg_in[0]);
        cfg_out.limit = cfg_in[LIM_W:1];
    end
endmodule

// File: rtl/alert_ready_flag.sv
module alert_ready_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic read_i,
    input  logic mode_chg_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (read_i || mode_chg_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/alert_level_cmp.sv
module alert_level_cmp #(
    parameter int RES_W = 16,
    parameter int LIM_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic [RES_W-1:0] result_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             over_o
);
    localparam int PAD_W = RES_W - LIM_W;

    logic signed [RES_W-1:0] lim_ext;
    logic                    over_now;

    always_comb begin
        lim_ext  = $signed({limit_i, {PAD_W{1'b0}}});
        over_now = $signed(result_i) > lim_ext;
    end

    always_ff @(posedge clk) begin
        if (rst)
            over_o <= 1'b0;
        else if (upd_i)
            over_o <= over_now;
    end
endmodule

// File: rtl/alert_drive.sv
module alert_drive #(
    parameter int RES_W = 16,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_new,
    input  logic             result_rd,
    input  logic [RES_W-1:0] result,
    input  logic [CFG_W-1:0] cfg_hi,
    output logic             pull_low
);
    import alert_pkg::*;

    localparam int LIM_W = CFG_W - 1;

    alert_cfg_t  cfg;
    alert_mode_e mode_q;
    logic        mode_chg;
    logic        rdy_flag;
    logic        over_flag;

    alert_cfg_split #(.CFG_W(CFG_W)) u_cfg (
        .cfg_in  (cfg_hi),
        .cfg_out (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_READY;
        else
            mode_q <= cfg.mode;
    end

    assign mode_chg = (cfg.mode != mode_q);

    alert_ready_flag u_rdy (
        .clk        (clk),
        .rst        (rst),
        .set_i      (data_new),
        .read_i     (result_rd),
        .mode_chg_i (mode_chg),
        .flag_o     (rdy_flag)
    );

    alert_level_cmp #(.RES_W(RES_W), .LIM_W(LIM_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (data_new),
        .result_i (result),
        .limit_i  (cfg.limit),
        .over_o   (over_flag)
    );

    always_comb begin
        unique case (mode_q)
            MODE_LIMIT: pull_low = over_flag;
            default:    pull_low = rdy_flag;
        endcase
    end
endmodule

// File: rtl/alert_drive_chk.sv
module alert_drive_chk #(
    parameter int RES_W = 16,
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             data_new,
    input logic             result_rd,
    input logic [RES_W-1:0] result,
    input logic [CFG_W-1:0] cfg_hi,
    input logic             pull_low
);
    localparam int LIM_W = CFG_W - 1;
    localparam int PAD_W = RES_W - LIM_W;

    // R2
    p_ready_set_r2: assert property (@(posedge clk) disable iff (rst)
        (data_new && !cfg_hi[0]) |=> pull_low);

    // R3
    p_ready_release_r3: assert property (@(posedge clk) disable iff (rst)
        (result_rd && !data_new && !cfg_hi[0]) |=> !pull_low);

    // R6
    p_limit_eval_r6: assert property (@(posedge clk) disable iff (rst)
        (data_new && cfg_hi[0]) |=>
            (pull_low == ($signed($past(result)) >
                          $signed({$past(cfg_hi[LIM_W:1]), {PAD_W{1'b0}}}))));

    // R7
    p_limit_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!data_new && cfg_hi[0] && $past(cfg_hi[0])) |=> $stable(pull_low));

    // R8
    p_mode_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_hi[0]) && !data_new) |=> !pull_low);
endmodule

bind alert_drive alert_drive_chk #(.RES_W(RES_W), .CFG_W(CFG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .data_new  (data_new),
    .result_rd (result_rd),
    .result    (result),
    .cfg_hi    (cfg_hi),
    .pull_low  (pull_low)
);

// File: tb/alert_drive_tb.sv
`timescale 1ns/1ps
module alert_drive_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        data_new;
    logic        result_rd;
    logic [15:0] result;
    logic [7:0]  cfg_hi;
    logic        pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    bit m_mode, m_rdy, m_over;

    always #4 clk = ~clk;

    alert_drive u_dut (
        .clk(clk), .rst(rst), .data_new(data_new), .result_rd(result_rd),
        .result(result), .cfg_hi(cfg_hi), .pull_low(pull_low)
    );

    function automatic bit ref_over(input logic [15:0] r, input logic [6:0] t);
        int rv, tv;
        rv = r[15] ? int'(r) - 65536 : int'(r);
        tv = t[6] ? (int'(t) - 128) * 512 : int'(t) * 512;
        return rv > tv;
    endfunction

    task automatic check(input string req, input bit exp);
        checks++;
        if (pull_low !== exp) begin
            fails++;
            $display("FAIL %s: pull_low=%0b expected %0b at %0t", req, pull_low, exp, $time);
        end
    endtask

    task automatic step(input bit nd, input bit rd, input logic [15:0] res,
                        input logic [7:0] cfg, input string req);
        @(negedge clk);
        data_new = nd; result_rd = rd; result = res; cfg_hi = cfg;
        @(posedge clk);
        if (nd) begin
            m_over = ref_over(res, cfg[7:1]);
            m_rdy  = 1;
        end else if (rd || (cfg[0] != m_mode)) begin
            m_rdy = 0;
        end
        m_mode = cfg[0];
        #1;
        check(req, m_mode ? m_over : m_rdy);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234abcd;
        void'($urandom(seed));
        rst = 1; data_new = 0; result_rd = 0; result = 16'h7fff; cfg_hi = 8'h00;
        m_mode = 0; m_rdy = 0; m_over = 0;
        repeat (3) @(posedge clk);
        #1; check("R1", 1'b0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1; check("R1", 1'b0);

        // data-ready mode
        step(1, 0, 16'h1440, 8'h00, "R2");
        step(0, 0, 16'h0000, 8'h00, "R5");
        step(0, 0, 16'h0000, 8'h00, "R5");
        step(0, 1, 16'h0000, 8'h00, "R3");
        step(0, 0, 16'h0000, 8'h00, "R3");
        step(1, 1, 16'h0a00, 8'h00, "R4");
        step(0, 0, 16'h0000, 8'h00, "R4");
        // mode change clears pending flag
        step(0, 0, 16'h0000, 8'h01, "R8");
        step(0, 0, 16'h0000, 8'h00, "R8");
        // threshold edges: limit 3 -> 0x0600
        step(1, 0, 16'h0601, 8'h07, "R6");
        step(1, 0, 16'h0600, 8'h07, "R6");
        step(1, 0, 16'h05ff, 8'h07, "R6");
        // negative limit -1 -> 0xfe00
        step(1, 0, 16'hfe00, 8'hff, "R6");
        step(1, 0, 16'hfe01, 8'hff, "R6");
        step(1, 0, 16'h8000, 8'hff, "R6");
        // positive result vs negative limit, negative result vs zero limit
        step(1, 0, 16'h0000, 8'h81, "R6");
        step(1, 0, 16'hffff, 8'h01, "R6");
        // hold: limit change and read ignored until update
        step(1, 0, 16'h0400, 8'h01, "R6");
        step(0, 1, 16'h0000, 8'h7f, "R7");
        step(0, 0, 16'h7fff, 8'h7f, "R7");
        step(1, 0, 16'h0400, 8'h7f, "R7");
        // over flag tracked in data-ready mode
        step(0, 0, 16'h0000, 8'h00, "R8");
        step(1, 0, 16'h3f80, 8'h20, "R2");
        step(0, 0, 16'h0000, 8'h21, "R9");
        step(1, 0, 16'h0000, 8'h20, "R9");
        step(0, 0, 16'h0000, 8'h21, "R9");

        for (int i = 0; i < 3000; i++) begin
            bit nd, rd, mflip;
            logic [7:0] cfg;
            string req;
            nd = ($urandom % 4) == 0;
            rd = ($urandom % 5) == 0;
            mflip = ($urandom % 16) == 0;
            cfg = {7'($urandom), cfg_hi[0] ^ mflip};
            if (cfg[0]) req = nd ? "R6" : "R7";
            else if (nd) req = rd ? "R4" : "R2";
            else if (mflip) req = "R8";
            else req = rd ? "R3" : "R5";
            step(nd, rd, 16'($urandom), cfg, req);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule